// File: doc/BRIEF.md
# DAC Front-End Sync FIFO with Phase Divider

This block sits between the sample source and the interpolation chain of a digital-to-analog converter. Each incoming 16-bit sample carries one sideband bit that does two jobs: as a level it enables the output, and as a rising edge it marks a synchronization point. The bit is stored in an 8-entry FIFO next to its sample. On the read side, a stored bit of 0 turns that sample into a zero at the output. A rising edge of the bit, seen on the write side, realigns the FIFO. It also restarts the shared clock divider that produces the interpolator clock enables.

A software sync input does the same realignment without a pin edge. The FIFO pointers are realigned relative to the write pointer, so a stream that is already in its nominal alignment passes through a sync event undisturbed. An occasional one-cycle zero in the sideband bit blanks exactly one sample and resynchronizes nothing that was already correct. Pointer collisions set a sticky error flag, and only the next sync event clears it.

Top module: `dac_sync_fifo`

## Requirements
- R1: After reset, data_o = 0, out_en_o = 0, err_o = 0 and ce_o = 3'b111. The FIFO holds 4 blank entries, so the first 4 reads return blank samples.
- R2: With one write and one read per cycle and the FIFO at its nominal fill of 4, a word written at clock edge t appears on data_o after edge t+4, with out_en_o = 1 when its sideband bit is 1.
- R3: A read of an entry whose stored sideband bit is 0 gives data_o = 0 and out_en_o = 0, whatever data was written.
- R4: A hardware sync event is a written word with sideband bit 1 whose previously written word had sideband bit 0. The first write after reset counts as following a 0. Repeated 1s or repeated 0s cause no event.
- R5: On a sync event the read pointer is set to the post-event write pointer minus 4. The word written in the event cycle then appears on data_o exactly 4 reads later, whatever the fill was before.
- R6: ce_o[k] asserts once every 2^(k+1) cycles (bit 0 divides by 2, bit 1 by 4, bit 2 by 8). In the cycle after a sync event edge, all three bits are 1.
- R7: A pulse on sw_sync_i performs the same pointer realignment and divider restart as a hardware sync event, without any write.
- R8: A write while 8 entries are stored and no read is requested is dropped, and err_o is 1 after that edge.
- R9: A read while the FIFO is empty gives data_o = 0 and out_en_o = 0 and sets err_o after that edge.
- R10: err_o stays 1 until a sync event, hardware or software. The event edge clears it.
- R11: With rd_en_i = 0, data_o and out_en_o hold their values.
- R12: A sideband stream of steady 1s with an occasional 1101 nibble, at nominal fill, gives a continuous output in which only the word carrying the 0 is blanked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for data_i and sync_i |
| sync_i | input | 1 | Sideband bit: output enable level, rising edge is a sync event |
| data_i | input | 16 | Input sample |
| rd_en_i | input | 1 | Read strobe toward the interpolator |
| sw_sync_i | input | 1 | Software sync request pulse |
| data_o | output | 16 | Output sample, zero when blanked |
| out_en_o | output | 1 | Sideband bit of the sample on data_o |
| ce_o | output | 3 | Divided clock enables: /2, /4, /8 |
| err_o | output | 1 | Sticky pointer collision flag |

## Verification
In steady streaming a written sample reaches data_o after the fourth following edge. err_o changes on the edge of the colliding access. ce_o shows the restarted phase in the cycle after the event edge, because it is decoded from the divider counter register. The bench drives inputs on the falling edge and samples one falling edge later, so each check reads the registers updated by exactly the edge it targets. It keeps its own model of the sideband history and the divider count to predict these values.

// File: rtl/dac_sync_pkg.sv
package dac_sync_pkg;
  parameter int DATA_W  = 16;
  parameter int DEPTH   = 8;
  parameter int OFFSET  = DEPTH / 2;
  parameter int NUM_DIV = 3;

  typedef struct packed {
    logic              en;
    logic [DATA_W-1:0] data;
  } fifo_entry_t;
endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic sync_i,
  input  logic sw_sync_i,
  output logic evt_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      prev_q <= 1'b0;
    else if (wr_en_i) prev_q <= sync_i;
  end

  assign evt_o = (wr_en_i & sync_i & ~prev_q) | sw_sync_i;
endmodule

// File: rtl/phase_div.sv
module phase_div #(
  parameter int NUM_DIV = dac_sync_pkg::NUM_DIV
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restart_i,
  output logic [NUM_DIV-1:0] ce_o
);
  logic [NUM_DIV-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  for (genvar k = 0; k < NUM_DIV; k++) begin : g_ce
    assign ce_o[k] = (cnt_q[k:0] == '0);
  end
endmodule

// File: rtl/sync_fifo_core.sv
module sync_fifo_core
  import dac_sync_pkg::*;
#(
  parameter int DW     = DATA_W,
  parameter int DEP    = DEPTH,
  parameter int OFS    = OFFSET,
  localparam int AW    = $clog2(DEP),
  localparam int PW    = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          en_i,
  input  logic [DW-1:0] data_i,
  input  logic          rd_en_i,
  input  logic          realign_i,
  output logic [DW-1:0] data_o,
  output logic          en_o,
  output logic          err_o,
  output logic [PW-1:0] fill_o
);
  logic [DW:0]   mem_q [DEP];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q, wr_ptr_n, rd_ptr_n;
  logic          full, empty, wr_ok, rd_ok, ovf, udf;
  logic [DW:0]   rd_word;

  assign fill_o  = wr_ptr_q - rd_ptr_q;
  assign full    = (fill_o == PW'(DEP));
  assign empty   = (fill_o == '0);
  assign rd_ok   = rd_en_i & ~empty;
  assign wr_ok   = wr_en_i & (~full | rd_ok);
  assign ovf     = wr_en_i & full & ~rd_en_i;
  assign udf     = rd_en_i & empty;
  assign rd_word = mem_q[rd_ptr_q[AW-1:0]];

  assign wr_ptr_n = wr_ptr_q + PW'(wr_ok);
  // realign read side to sit OFS entries behind the write side
  assign rd_ptr_n = realign_i ? (wr_ptr_n - PW'(OFS)) : (rd_ptr_q + PW'(rd_ok));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= PW'(OFS);
      rd_ptr_q <= '0;
      for (int i = 0; i < DEP; i++) mem_q[i] <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_n;
      rd_ptr_q <= rd_ptr_n;
      if (wr_ok) mem_q[wr_ptr_q[AW-1:0]] <= {en_i, data_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      en_o   <= 1'b0;
    end else if (rd_en_i) begin
      if (rd_ok && rd_word[DW]) begin
        data_o <= rd_word[DW-1:0];
        en_o   <= 1'b1;
      end else begin
        data_o <= '0;
        en_o   <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_o <= 1'b0;
    else if (realign_i) err_o <= 1'b0;
    else if (ovf | udf) err_o <= 1'b1;
  end
endmodule

// File: rtl/dac_sync_fifo.sv
module dac_sync_fifo
  import dac_sync_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               sync_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic               rd_en_i,
  input  logic               sw_sync_i,
  output logic [DATA_W-1:0]  data_o,
  output logic               out_en_o,
  output logic [NUM_DIV-1:0] ce_o,
  output logic               err_o
);
  localparam int PW = $clog2(DEPTH) + 1;

  logic          sync_evt;
  logic [PW-1:0] fill_lvl;

  sync_edge_det u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .sync_i   (sync_i),
    .sw_sync_i(sw_sync_i),
    .evt_o    (sync_evt)
  );

  sync_fifo_core u_fifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .en_i     (sync_i),
    .data_i   (data_i),
    .rd_en_i  (rd_en_i),
    .realign_i(sync_evt),
    .data_o   (data_o),
    .en_o     (out_en_o),
    .err_o    (err_o),
    .fill_o   (fill_lvl)
  );

  phase_div u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(sync_evt),
    .ce_o     (ce_o)
  );
endmodule

// File: rtl/dac_sync_fifo_chk.sv
module dac_sync_fifo_chk
  import dac_sync_pkg::*;
#(
  localparam int PW = $clog2(DEPTH) + 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic               rd_en_i,
  input logic [DATA_W-1:0]  data_o,
  input logic               out_en_o,
  input logic [NUM_DIV-1:0] ce_o,
  input logic               err_o,
  input logic               sync_evt,
  input logic [PW-1:0]      fill_lvl
);
  assert_blank_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_o |-> data_o == '0);

  assert_div_align_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_evt |=> &ce_o);

  assert_ce_nest_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_o[NUM_DIV-1] |-> &ce_o);

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !rd_en_i && fill_lvl == PW'(DEPTH) && !sync_evt) |=> err_o);

  assert_fill_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_lvl <= PW'(DEPTH));

  assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !sync_evt) |=> err_o);

  assert_err_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_evt |=> !err_o);

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> ($stable(data_o) && $stable(out_en_o)));
endmodule

bind dac_sync_fifo dac_sync_fifo_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i),
  .data_o  (data_o),
  .out_en_o(out_en_o),
  .ce_o    (ce_o),
  .err_o   (err_o),
  .sync_evt(sync_evt),
  .fill_lvl(fill_lvl)
);

// File: tb/sim_dac_sync_fifo.sv
module sim_dac_sync_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, sync = 1'b0, rd_en = 1'b0, sw_sync = 1'b0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic        oen, err;
  logic [2:0]  ce;
  int          total = 0, bad = 0;
  bit          done = 0;

  // sideband pattern, bit i drives step i: 1111 with 1101 nibbles
  localparam logic [19:0] PAT = 20'b1111_1011_1111_1011_1111;
  localparam int STEPS = 20;

  always #10 clk = ~clk;

  dac_sync_fifo u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .sync_i(sync), .data_i(din),
    .rd_en_i(rd_en), .sw_sync_i(sw_sync), .data_o(dout), .out_en_o(oen),
    .ce_o(ce), .err_o(err)
  );

  function automatic logic [15:0] dat(input int i);
    return 16'hA000 + 16'(i * 16'h0105);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic r, input logic s,
                     input logic [15:0] d, input logic sw);
    wr_en = w; rd_en = r; sync = s; din = d; sw_sync = sw;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; rd_en = 0; sw_sync = 0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hang exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic        prev_m;
    int          cnt_m;
    logic [15:0] held;

    repeat (2) @(negedge clk);
    chk("R1 data", dout, 0);
    chk("R1 en", oen, 0);
    chk("R1 err", err, 0);
    chk("R1 ce", ce, 3'b111);
    rst_n = 1'b1;
    @(negedge clk);

    // streaming table: one write and one read per cycle
    prev_m = 1'b0;
    cnt_m  = 0;
    for (int i = 0; i < STEPS; i++) begin
      logic        e;
      logic [15:0] xd;
      logic [2:0]  xce;
      cyc(1, 1, PAT[i], dat(i), 0);
      cnt_m  = (PAT[i] && !prev_m) ? 0 : cnt_m + 1;
      prev_m = PAT[i];
      if (i < 4) begin e = 0; xd = 0; end
      else begin e = PAT[i-4]; xd = e ? dat(i-4) : 16'h0; end
      xce = {cnt_m % 8 == 0, cnt_m % 4 == 0, cnt_m % 2 == 0};
      chk("R2 R12 data", dout, xd);
      chk("R3 R12 en", oen, e);
      chk("R4 R6 ce", ce, xce);
    end

    // R11: no read holds output
    held = dout;
    cyc(0, 0, 0, 16'h7777, 0);
    chk("R11 hold", dout, held);

    // R7: software sync restarts divider
    cyc(0, 0, 0, 0, 1);
    chk("R7 ce", ce, 3'b111);
    cyc(0, 0, 0, 0, 0);
    chk("R6 ce cnt1", ce, 3'b000);
    cyc(0, 0, 0, 0, 0);
    chk("R6 ce cnt2", ce, 3'b001);

    // R5: misalign to fill 6, then hardware event realigns to 4
    cyc(1, 0, 0, 16'h1111, 0);
    cyc(1, 0, 0, 16'h2222, 0);
    cyc(1, 1, 1, 16'h5A5A, 0);
    chk("R5 ce", ce, 3'b111);
    for (int k = 0; k < 4; k++) begin
      cyc(1, 1, 1, 16'h0F00 + 16'(k), 0);
      if (k == 2) begin
        chk("R3 blank data", dout, 0);
        chk("R3 blank en", oen, 0);
      end
    end
    chk("R5 data", dout, 16'h5A5A);
    chk("R5 en", oen, 1);

    // R8: fill to 8, then one more write is dropped
    for (int k = 0; k < 4; k++) cyc(1, 0, 1, 16'hC000 + 16'(k), 0);
    chk("R8 no err at full", err, 0);
    cyc(1, 0, 1, 16'hDEAD, 0);
    chk("R8 err", err, 1);
    for (int k = 0; k < 8; k++) cyc(0, 1, 0, 0, 0);
    chk("R8 dropped", dout, 16'hC003);
    chk("R10 sticky", err, 1);

    // R10: software sync clears error and realigns
    cyc(0, 0, 0, 0, 1);
    chk("R10 sw clear", err, 0);
    for (int k = 0; k < 4; k++) cyc(0, 1, 0, 0, 0);
    chk("R7 realign", dout, 16'hC003);

    // R9: read when empty
    cyc(0, 1, 0, 0, 0);
    chk("R9 data", dout, 0);
    chk("R9 en", oen, 0);
    chk("R9 err", err, 1);

    // R10: hardware event clears error
    cyc(1, 1, 0, 16'h3333, 0);
    chk("R10 still set", err, 1);
    cyc(1, 1, 1, 16'hBEEF, 0);
    chk("R10 hw clear", err, 0);
    chk("R6 hw ce", ce, 3'b111);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule